// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between an A bus and a B bus in groups of lanes. Every group has one storage register per direction, and each direction has its own capture strobe, its own select and its own output enable. A direction can pass the opposite bus through live, or it can present the value held in its register. Each bus side is modelled as an input vector, an output vector and an output-enable bit. The tri-state pad that merges them sits outside the block.

The two enables have opposite polarity. The A-to-B enable is active-high and the B-to-A enable is active-low. Capture does not depend on the select or enable inputs. A register loads on every clock cycle where its capture strobe is high. The value it loads is the effective bus value: the external input when that side is not driven, and the block's own output when it is. Both directions may be live and enabled at once. In that case each bus drives the other, which forms a combinational loop. The block breaks the loop with a hold register that keeps the last value a direction carried, so the bus keeps its data without using the storage registers.

The groups use identical logic and share no control inputs. A synchronous active-high reset clears every register.

Top module: `dual_reg_xcvr`

## Requirements
- R1: `bOutEn[g]` is 1 exactly when `abEnable[g]` is 1, and B is driven only then (the A-to-B enable is active-high).
- R2: `aOutEn[g]` is 1 exactly when `baEnableN[g]` is 0, and A is driven only then (the B-to-A enable is active-low).
- R3: On a clock edge with `abCapture[g]` = 1, the A register loads the effective A value, whatever the select and enable inputs are. With `abCapture[g]` = 0 it holds its value.
- R4: On a clock edge with `baCapture[g]` = 1, the B register loads the effective B value, whatever the select and enable inputs are. With `baCapture[g]` = 0 it holds its value.
- R5: While B is driven and A is not, `abSelStored[g]` = 0 puts the live `aIn` onto `bOut`, and `abSelStored[g]` = 1 puts the A register onto `bOut`.
- R6: While A is driven and B is not, `baSelStored[g]` = 0 puts the live `bIn` onto `aOut`, and `baSelStored[g]` = 1 puts the B register onto `aOut`.
- R7: With `abEnable` = 0 and `baEnableN` = 1, both output enables are 0 (isolation), and both registers still capture the external inputs.
- R8: In live A-to-B mode, with both capture strobes high on the same edge, both registers load the A data. The mirrored live B-to-A case loads the B data into both registers.
- R9: With both directions enabled and live, both buses show the last value driven before the loop formed. They keep it for as long as the loop lasts, and `aIn` and `bIn` have no effect on either bus.
- R10: With both directions enabled and both selects at 1, `aOut` shows the B register and `bOut` shows the A register at the same time.
- R11: A group's outputs and registers do not depend on any other group's inputs or controls.
- R12: While `rst` = 1, each clock edge clears both registers and the hold register of every group to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous reset, active-high |
| abCapture | input | NUM_GROUPS | Per-group capture strobe for the A register |
| baCapture | input | NUM_GROUPS | Per-group capture strobe for the B register |
| abSelStored | input | NUM_GROUPS | Per-group A-to-B select: 0 live, 1 stored |
| baSelStored | input | NUM_GROUPS | Per-group B-to-A select: 0 live, 1 stored |
| abEnable | input | NUM_GROUPS | Per-group A-to-B output enable, active-high |
| baEnableN | input | NUM_GROUPS | Per-group B-to-A output enable, active-low |
| aIn | input | NUM_GROUPS*LANE_W | External value on the A bus |
| bIn | input | NUM_GROUPS*LANE_W | External value on the B bus |
| aOut | output | NUM_GROUPS*LANE_W | Value the block drives onto A |
| aOutEn | output | NUM_GROUPS | Per-group A drive enable |
| bOut | output | NUM_GROUPS*LANE_W | Value the block drives onto B |
| bOutEn | output | NUM_GROUPS | Per-group B drive enable |

## Verification
The bench uses the default build: two groups of eight lanes each. With two groups, one group can be left idle or given unrelated traffic while the other cycles through isolation, live, stored and loop modes, which checks that the groups do not affect each other. Eight lanes leave room for distinct byte patterns, so a value read back from a register can always be told apart from the live input on either bus. In particular, the value held by the loop differs from every input applied while the loop lasts.

// File: rtl/dual_reg_xcvr_pkg.sv
package dual_reg_xcvr_pkg;

  // Decoded per-group strobes passed from control to datapath.
  typedef struct packed {
    logic driveA;     // block drives the A bus
    logic driveB;     // block drives the B bus
    logic storedToA;  // A side takes the B register
    logic storedToB;  // B side takes the A register
    logic loopHold;   // both directions live: resolve through hold register
    logic capA;       // load A register this edge
    logic capB;       // load B register this edge
  } xcvrStrobe_t;

endpackage

// File: rtl/dual_reg_xcvr_ctrl.sv
module dual_reg_xcvr_ctrl
  import dual_reg_xcvr_pkg::*;
(
  input  logic        abCaptureI,
  input  logic        baCaptureI,
  input  logic        abSelStoredI,
  input  logic        baSelStoredI,
  input  logic        abEnableI,
  input  logic        baEnableNI,
  output xcvrStrobe_t strobeO
);

  logic driveA;
  logic driveB;

  always_comb begin
    driveA = ~baEnableNI;
    driveB = abEnableI;
    strobeO.driveA    = driveA;
    strobeO.driveB    = driveB;
    strobeO.storedToA = baSelStoredI;
    strobeO.storedToB = abSelStoredI;
    strobeO.loopHold  = driveA & driveB & ~baSelStoredI & ~abSelStoredI;
    strobeO.capA      = abCaptureI;
    strobeO.capB      = baCaptureI;
  end

endmodule

// File: rtl/dual_reg_xcvr_dp.sv
module dual_reg_xcvr_dp
  import dual_reg_xcvr_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  xcvrStrobe_t       strobeI,
  input  logic [LANE_W-1:0] aInI,
  input  logic [LANE_W-1:0] bInI,
  output logic [LANE_W-1:0] aOutO,
  output logic              aOutEnO,
  output logic [LANE_W-1:0] bOutO,
  output logic              bOutEnO
);

  logic [LANE_W-1:0] regA;
  logic [LANE_W-1:0] regB;
  logic [LANE_W-1:0] holdQ;
  logic [LANE_W-1:0] aPre;
  logic [LANE_W-1:0] bPre;
  logic [LANE_W-1:0] aEff;
  logic [LANE_W-1:0] bEff;

  // Stored paths resolve first; a live path then copies the opposite
  // side. Outside the loop case at most one side is live, so no cycle.
  always_comb begin
    aPre = (strobeI.driveA && strobeI.storedToA) ? regB : aInI;
    bPre = (strobeI.driveB && strobeI.storedToB) ? regA : bInI;
    if (strobeI.loopHold) begin
      aEff = holdQ;
      bEff = holdQ;
    end else begin
      bEff = (strobeI.driveB && !strobeI.storedToB) ? aPre : bPre;
      aEff = (strobeI.driveA && !strobeI.storedToA) ? bPre : aPre;
    end
  end

  assign aOutO   = aEff;
  assign bOutO   = bEff;
  assign aOutEnO = strobeI.driveA;
  assign bOutEnO = strobeI.driveB;

  always_ff @(posedge clk) begin
    if (rst) begin
      regA  <= '0;
      regB  <= '0;
      holdQ <= '0;
    end else begin
      if (strobeI.capA) regA <= aEff;
      if (strobeI.capB) regB <= bEff;
      if (!strobeI.loopHold) begin
        if (strobeI.driveB)      holdQ <= bEff;
        else if (strobeI.driveA) holdQ <= aEff;
      end
    end
  end

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import dual_reg_xcvr_pkg::*;
#(
  parameter int LANE_W     = 8,
  parameter int NUM_GROUPS = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_GROUPS-1:0]        abCapture,
  input  logic [NUM_GROUPS-1:0]        baCapture,
  input  logic [NUM_GROUPS-1:0]        abSelStored,
  input  logic [NUM_GROUPS-1:0]        baSelStored,
  input  logic [NUM_GROUPS-1:0]        abEnable,
  input  logic [NUM_GROUPS-1:0]        baEnableN,
  input  logic [NUM_GROUPS*LANE_W-1:0] aIn,
  input  logic [NUM_GROUPS*LANE_W-1:0] bIn,
  output logic [NUM_GROUPS*LANE_W-1:0] aOut,
  output logic [NUM_GROUPS-1:0]        aOutEn,
  output logic [NUM_GROUPS*LANE_W-1:0] bOut,
  output logic [NUM_GROUPS-1:0]        bOutEn
);

  localparam int BUS_W = NUM_GROUPS * LANE_W;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    xcvrStrobe_t strobe;

    dual_reg_xcvr_ctrl u_ctrl (
      .abCaptureI   (abCapture[g]),
      .baCaptureI   (baCapture[g]),
      .abSelStoredI (abSelStored[g]),
      .baSelStoredI (baSelStored[g]),
      .abEnableI    (abEnable[g]),
      .baEnableNI   (baEnableN[g]),
      .strobeO      (strobe)
    );

    dual_reg_xcvr_dp #(.LANE_W(LANE_W)) u_dp (
      .clk     (clk),
      .rst     (rst),
      .strobeI (strobe),
      .aInI    (aIn[g*LANE_W +: LANE_W]),
      .bInI    (bIn[g*LANE_W +: LANE_W]),
      .aOutO   (aOut[g*LANE_W +: LANE_W]),
      .aOutEnO (aOutEn[g]),
      .bOutO   (bOut[g*LANE_W +: LANE_W]),
      .bOutEnO (bOutEn[g])
    );
  end

  if (BUS_W != NUM_GROUPS * LANE_W) begin : g_bad_width
    $error("bus width mismatch");
  end

endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
  parameter int LANE_W     = 8,
  parameter int NUM_GROUPS = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_GROUPS-1:0]        abCapture,
  input logic [NUM_GROUPS-1:0]        baCapture,
  input logic [NUM_GROUPS-1:0]        abSelStored,
  input logic [NUM_GROUPS-1:0]        baSelStored,
  input logic [NUM_GROUPS-1:0]        abEnable,
  input logic [NUM_GROUPS-1:0]        baEnableN,
  input logic [NUM_GROUPS*LANE_W-1:0] aIn,
  input logic [NUM_GROUPS*LANE_W-1:0] bIn,
  input logic [NUM_GROUPS*LANE_W-1:0] aOut,
  input logic [NUM_GROUPS-1:0]        aOutEn,
  input logic [NUM_GROUPS*LANE_W-1:0] bOut,
  input logic [NUM_GROUPS-1:0]        bOutEn
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    logic loopNow;
    assign loopNow = abEnable[g] && !baEnableN[g] && !abSelStored[g] && !baSelStored[g];

    a_r7_isolated: assert property (@(posedge clk) disable iff (rst)
      (!abEnable[g] && baEnableN[g]) |-> (!aOutEn[g] && !bOutEn[g]));

    a_r5_live_to_b: assert property (@(posedge clk) disable iff (rst)
      (abEnable[g] && !abSelStored[g] && baEnableN[g])
        |-> bOut[g*LANE_W +: LANE_W] == aIn[g*LANE_W +: LANE_W]);

    a_r6_live_to_a: assert property (@(posedge clk) disable iff (rst)
      (!baEnableN[g] && !baSelStored[g] && !abEnable[g])
        |-> aOut[g*LANE_W +: LANE_W] == bIn[g*LANE_W +: LANE_W]);

    a_r3_capture_a: assert property (@(posedge clk) disable iff (rst)
      (abCapture[g] && baEnableN[g])
        |=> (!(abEnable[g] && abSelStored[g])
             || bOut[g*LANE_W +: LANE_W] == $past(aIn[g*LANE_W +: LANE_W])));

    a_r3_hold_a: assert property (@(posedge clk) disable iff (rst)
      (!abCapture[g] && abEnable[g] && abSelStored[g])
        |=> (!(abEnable[g] && abSelStored[g])
             || $stable(bOut[g*LANE_W +: LANE_W])));

    a_r4_capture_b: assert property (@(posedge clk) disable iff (rst)
      (baCapture[g] && !abEnable[g])
        |=> (!(!baEnableN[g] && baSelStored[g])
             || aOut[g*LANE_W +: LANE_W] == $past(bIn[g*LANE_W +: LANE_W])));

    a_r9_loop_holds: assert property (@(posedge clk) disable iff (rst)
      (loopNow && $past(loopNow))
        |-> (aOut[g*LANE_W +: LANE_W] == bOut[g*LANE_W +: LANE_W]
             && $stable(aOut[g*LANE_W +: LANE_W])));
  end

endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.LANE_W(LANE_W), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk(clk), .rst(rst), .abCapture(abCapture), .baCapture(baCapture),
  .abSelStored(abSelStored), .baSelStored(baSelStored), .abEnable(abEnable),
  .baEnableN(baEnableN), .aIn(aIn), .bIn(bIn), .aOut(aOut), .aOutEn(aOutEn),
  .bOut(bOut), .bOutEn(bOutEn)
);

// File: tb/dual_reg_xcvr_bench.sv
module dual_reg_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int G = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [G-1:0]   abCapture = '0, baCapture = '0, abSelStored = '0, baSelStored = '0;
  logic [G-1:0]   abEnable = '0, baEnableN = '1;
  logic [G*W-1:0] aIn = '0, bIn = '0;
  logic [G*W-1:0] aOut, bOut;
  logic [G-1:0]   aOutEn, bOutEn;

  dual_reg_xcvr #(.LANE_W(W), .NUM_GROUPS(G)) u_dual_reg_xcvr (
    .clk(clk), .rst(rst), .abCapture(abCapture), .baCapture(baCapture),
    .abSelStored(abSelStored), .baSelStored(baSelStored), .abEnable(abEnable),
    .baEnableN(baEnableN), .aIn(aIn), .bIn(bIn), .aOut(aOut), .aOutEn(aOutEn),
    .bOut(bOut), .bOutEn(bOutEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    int       req;
    int       grp;
    logic     chkA;
    logic     expAOe;
    logic [W-1:0] expA;
    logic     chkB;
    logic     expBOe;
    logic [W-1:0] expB;
  } item_t;

  item_t scoreQ[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic setCtl(int g, bit cab, bit cba, bit sab, bit sba, bit oeab, bit oeban);
    abCapture[g] = cab;  baCapture[g] = cba;
    abSelStored[g] = sab; baSelStored[g] = sba;
    abEnable[g] = oeab;  baEnableN[g] = oeban;
  endtask

  task automatic setData(int g, logic [W-1:0] a, logic [W-1:0] b);
    aIn[g*W +: W] = a;
    bIn[g*W +: W] = b;
  endtask

  // Driver side: push what the outputs must show in this cycle.
  task automatic expectOut(int req, int g, bit chkA, bit aOe, logic [W-1:0] a,
                           bit chkB, bit bOe, logic [W-1:0] b);
    item_t it;
    it.req = req; it.grp = g;
    it.chkA = chkA; it.expAOe = aOe; it.expA = a;
    it.chkB = chkB; it.expBOe = bOe; it.expB = b;
    scoreQ.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Monitor: compare pending items away from the active edge.
  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      item_t it;
      it = scoreQ.pop_front();
      if (it.chkA) begin
        compared++;
        if (aOutEn[it.grp] !== it.expAOe ||
            (it.expAOe && aOut[it.grp*W +: W] !== it.expA)) begin
          mismatched++;
          $display("FAIL R%0d grp%0d A side: got oe=%b val=%h, want oe=%b val=%h",
                   it.req, it.grp, aOutEn[it.grp], aOut[it.grp*W +: W], it.expAOe, it.expA);
        end
      end
      if (it.chkB) begin
        compared++;
        if (bOutEn[it.grp] !== it.expBOe ||
            (it.expBOe && bOut[it.grp*W +: W] !== it.expB)) begin
          mismatched++;
          $display("FAIL R%0d grp%0d B side: got oe=%b val=%h, want oe=%b val=%h",
                   it.req, it.grp, bOutEn[it.grp], bOut[it.grp*W +: W], it.expBOe, it.expB);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #1;
    // R12: reset state, read both registers through the stored paths
    setCtl(0, 1, 1, 1, 1, 1, 0);
    setData(0, 8'hFF, 8'hFF);
    tick(); tick();
    setCtl(0, 0, 0, 1, 1, 1, 0);
    expectOut(12, 0, 1, 1, 8'h00, 1, 1, 8'h00);
    tick();
    rst = 1'b0;

    // R7: isolation, both registers still capture
    setCtl(0, 1, 1, 0, 0, 0, 1);
    setData(0, 8'h3C, 8'hA5);
    expectOut(7, 0, 1, 0, 8'h00, 1, 0, 8'h00);
    tick();
    // R10 / R7: both stored directions at once, inputs changed
    setCtl(0, 0, 0, 1, 1, 1, 0);
    setData(0, 8'h11, 8'h22);
    expectOut(10, 0, 1, 1, 8'hA5, 1, 1, 8'h3C);
    tick();

    // R3: capture with stored select while A is undriven
    setCtl(0, 1, 0, 1, 0, 1, 1);
    setData(0, 8'h5A, 8'h00);
    expectOut(3, 0, 1, 0, 8'h00, 1, 1, 8'h3C);
    tick();
    setCtl(0, 0, 0, 1, 0, 1, 1);
    setData(0, 8'h77, 8'h00);
    expectOut(3, 0, 0, 0, 8'h00, 1, 1, 8'h5A);
    tick();
    setData(0, 8'h99, 8'h00);
    expectOut(3, 0, 0, 0, 8'h00, 1, 1, 8'h5A); // R3 hold
    tick();

    // R5 / R1: live A to B, then B released
    setCtl(0, 0, 0, 0, 0, 1, 1);
    setData(0, 8'hC3, 8'h0F);
    expectOut(5, 0, 1, 0, 8'h00, 1, 1, 8'hC3);
    tick();
    setCtl(0, 0, 0, 0, 0, 0, 1);
    expectOut(1, 0, 0, 0, 8'h00, 1, 0, 8'h00);
    tick();

    // R8: live A to B with both strobes loads A data into both registers
    setCtl(0, 1, 1, 0, 0, 1, 1);
    setData(0, 8'h6E, 8'h01);
    expectOut(8, 0, 0, 0, 8'h00, 1, 1, 8'h6E);
    tick();
    setCtl(0, 0, 0, 1, 1, 1, 0);
    setData(0, 8'h02, 8'h03);
    expectOut(8, 0, 1, 1, 8'h6E, 1, 1, 8'h6E);
    tick();

    // R6 / R2: live B to A, then A released
    setCtl(0, 0, 0, 0, 0, 0, 0);
    setData(0, 8'h10, 8'hD2);
    expectOut(6, 0, 1, 1, 8'hD2, 1, 0, 8'h00);
    tick();
    setCtl(0, 0, 0, 0, 0, 0, 1);
    expectOut(2, 0, 1, 0, 8'h00, 0, 0, 8'h00);
    tick();

    // R8 mirrored: live B to A with both strobes
    setCtl(0, 1, 1, 0, 0, 0, 0);
    setData(0, 8'h20, 8'h4B);
    expectOut(8, 0, 1, 1, 8'h4B, 1, 0, 8'h00);
    tick();
    setCtl(0, 0, 0, 1, 1, 1, 0);
    setData(0, 8'h30, 8'h31);
    expectOut(8, 0, 1, 1, 8'h4B, 1, 1, 8'h4B);
    tick();

    // R4: B capture with enables in isolation, then stored read on A
    setCtl(0, 0, 1, 0, 1, 0, 1);
    setData(0, 8'h00, 8'hE7);
    tick();
    setCtl(0, 0, 0, 0, 1, 0, 0);
    setData(0, 8'h00, 8'h18);
    expectOut(4, 0, 1, 1, 8'hE7, 1, 0, 8'h00);
    tick();

    // R9: drive 81 live A to B, then close the loop
    setCtl(0, 0, 0, 0, 0, 1, 1);
    setData(0, 8'h81, 8'h00);
    expectOut(9, 0, 0, 0, 8'h00, 1, 1, 8'h81);
    tick();
    setCtl(0, 0, 0, 0, 0, 1, 0);
    setData(0, 8'h00, 8'hFF);
    expectOut(9, 0, 1, 1, 8'h81, 1, 1, 8'h81);
    tick();
    setCtl(0, 1, 0, 0, 0, 1, 0);
    setData(0, 8'h0F, 8'hF0);
    expectOut(9, 0, 1, 1, 8'h81, 1, 1, 8'h81);
    tick();
    // A register captured the looped value; read it out stored
    setCtl(0, 0, 0, 1, 0, 1, 1);
    setData(0, 8'h55, 8'h66);
    expectOut(9, 0, 1, 0, 8'h00, 1, 1, 8'h81);
    tick();

    // R11: group 1 untouched by group 0 activity, still at reset value
    setCtl(1, 0, 0, 1, 1, 1, 0);
    setData(1, 8'hAA, 8'hBB);
    expectOut(11, 1, 1, 1, 8'h00, 1, 1, 8'h00);
    tick();
    // group 1 captures while group 0 keeps its own register
    setCtl(1, 1, 1, 0, 0, 0, 1);
    setData(1, 8'h5C, 8'hC5);
    tick();
    setCtl(1, 0, 0, 1, 1, 1, 0);
    expectOut(11, 1, 1, 1, 8'hC5, 1, 1, 8'h5C);
    expectOut(11, 0, 0, 0, 8'h00, 1, 1, 8'h81);
    tick();
    tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule